// File: doc/BRIEF.md
# Synchronized Two-Flop JK State Machine

This block is a two-bit state machine made of two JK flip-flops on one clock. Bit 0 toggles or holds. Bit 1 is set by bit 0 and cleared by an external input. That input comes from outside the clock domain and may change at any moment, so it is never fed straight to the excitation logic.

A chain of synchronizing registers samples the input first. The last stage of the chain is the only copy the excitation logic sees. Both flip-flops therefore always act on the same sampled value. A late input change can then no longer push one flop into the new value while the other still uses the old one.

The cost is latency. A change on the raw input shows up in the state a fixed number of edges later. The length of the synchronizer chain is a parameter and defaults to two stages.

Top module: `jk_pair_fsm`

## Requirements
- R1: While `rst_ni` is low, `state_o` is 00 without waiting for a clock edge. Every synchronizer stage is also cleared to 0, so after release the machine first sees the input as 0 until a sampled 1 has moved down the chain.
- R2: Bit 0 is a JK flop with J = K = (synchronized input XNOR bit 1). On a rising edge it toggles when the synchronized input equals bit 1, and holds otherwise.
- R3: Bit 1 is a JK flop with J = bit 0 and K = synchronized input. The JK rules are: 00 holds, 10 sets, 01 clears, 11 toggles.
- R4: Index the present state and the synchronized input as {bit1, bit0, input}. Indices 0 to 7 give the next states 01, 00, 10, 11, 10, 01, 11, 00.
- R5: From state 01 with a synchronized input of 1, the next state is always 11 and never 10.
- R6: The raw input passes through `SYNC_STAGES` registers before it reaches the excitation logic. With the default of 2, a value applied before rising edge k first steers the state update at edge k+2.
- R7: `state_o[1]` carries bit 1 and `state_o[0]` carries bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock shared by both flops and the synchronizer |
| rst_ni | input | 1 | Active-low asynchronous clear of the state and the synchronizer |
| async_in_i | input | 1 | Raw input, asynchronous to the clock |
| state_o | output | 2 | Present state {bit1, bit0} |

## Verification
The reset clear is due at once, without a clock edge. The bench samples it a nanosecond after pulling `rst_ni` low in the middle of a cycle, before any edge arrives.

Each state update is due at the rising edge. A raw-input value steers that update only two edges after it is applied. The bench's reference model keeps its own two-deep history of the raw input and applies the transition table to the oldest entry.

The bench drives inputs just after a falling edge and compares outputs at the next falling edge. Every comparison therefore lands half a period after the register it concerns has updated.

// File: rtl/jk_pair_pkg.sv
package jk_pair_pkg;
  localparam int unsigned STATE_W = 2;

  typedef struct packed {
    logic j;
    logic k;
  } jk_ctrl_t;
endpackage

// File: rtl/jk_input_sync.sv
module jk_input_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/jk_excitation.sv
module jk_excitation
  import jk_pair_pkg::*;
(
  input  logic [STATE_W-1:0]           state_i,
  input  logic                         in_i,
  output jk_pair_pkg::jk_ctrl_t [STATE_W-1:0] ctrl_o
);
  logic t0;

  always_comb begin
    t0          = ~(in_i ^ state_i[1]);
    ctrl_o[0].j = t0;
    ctrl_o[0].k = t0;          // J=K: toggle or hold
    ctrl_o[1].j = state_i[0];
    ctrl_o[1].k = in_i;
  end
endmodule

// File: rtl/jk_flop.sv
module jk_flop
  import jk_pair_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  jk_ctrl_t ctrl_i,
  output logic     q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o <= 1'b0;
    end else begin
      unique case ({ctrl_i.j, ctrl_i.k})
        2'b00:   q_o <= q_o;
        2'b10:   q_o <= 1'b1;
        2'b01:   q_o <= 1'b0;
        default: q_o <= ~q_o;
      endcase
    end
  end
endmodule

// File: rtl/jk_pair_fsm.sv
module jk_pair_fsm
  import jk_pair_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               async_in_i,
  output logic [STATE_W-1:0] state_o
);
  logic                    in_sync;
  jk_ctrl_t [STATE_W-1:0]  ctrl;
  logic [STATE_W-1:0]      state_q;

  jk_input_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (async_in_i),
    .q_o    (in_sync)
  );

  jk_excitation u_exc (
    .state_i (state_q),
    .in_i    (in_sync),
    .ctrl_o  (ctrl)
  );

  for (genvar g = 0; g < STATE_W; g++) begin : g_bit
    jk_flop u_ff (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ctrl_i (ctrl[g]),
      .q_o    (state_q[g])
    );
  end

  assign state_o = state_q;
endmodule

// File: rtl/jk_pair_fsm_chk.sv
module jk_pair_fsm_chk #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       async_in_i,
  input logic [1:0] state_o
);
  logic [SYNC_STAGES:0] hist_q;
  logic                 ref_in;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= '0;
    else         hist_q <= {hist_q[SYNC_STAGES-1:0], async_in_i};
  end
  assign ref_in = hist_q[SYNC_STAGES-1];

  function automatic logic [1:0] ref_next(input logic [1:0] s, input logic i);
    case ({s, i})
      3'd0: return 2'b01;
      3'd1: return 2'b00;
      3'd2: return 2'b10;
      3'd3: return 2'b11;
      3'd4: return 2'b10;
      3'd5: return 2'b01;
      3'd6: return 2'b11;
      default: return 2'b00;
    endcase
  endfunction

  assert_reset_clear_R1: assert property (@(posedge clk_i)
    !rst_ni |-> state_o == 2'b00);

  assert_bit0_toggle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_in == state_o[1]) |=> state_o[0] != $past(state_o[0]));

  assert_bit0_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_in != state_o[1]) |=> $stable(state_o[0]));

  assert_bit1_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o[0] && !ref_in) |=> state_o[1]);

  assert_bit1_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!state_o[0] && ref_in) |=> !state_o[1]);

  assert_table_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> state_o == ref_next($past(state_o), $past(ref_in)));

  assert_no_split_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'b01 && ref_in) |=> state_o == 2'b11);
endmodule

bind jk_pair_fsm jk_pair_fsm_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .async_in_i (async_in_i),
  .state_o    (state_o)
);

// File: tb/tb_jk_pair_fsm.sv
`timescale 1ns/1ps
module tb_jk_pair_fsm;
  localparam int N = 2;
  localparam int NSTIM = 24;
  localparam logic [1:0] NEXT_TBL [8] =
    '{2'b01, 2'b00, 2'b10, 2'b11, 2'b10, 2'b01, 2'b11, 2'b00};
  localparam logic STIM [NSTIM] =
    '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0,
      1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic raw = 1'b0;
  logic [1:0] state;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [1:0] m_state;
  logic [N-1:0] m_pipe;

  always #2.5 clk = ~clk;

  jk_pair_fsm #(.SYNC_STAGES(N)) dut (
    .clk_i(clk), .rst_ni(rst_n), .async_in_i(raw), .state_o(state)
  );

  task automatic chk(input logic [1:0] act, input logic [1:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: state act=%b exp=%b at %0t", req, act, exp, $time);
    end
  endtask

  // drive after a falling edge, let one rising edge pass, return at next falling edge
  task automatic step(input logic v);
    raw = v;
    @(posedge clk);
    m_state = NEXT_TBL[{m_state, m_pipe[N-1]}];
    m_pipe  = {m_pipe[N-2:0], v};
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    m_state = 2'b00;
    m_pipe = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    m_state = 2'b00;
    m_pipe = '0;
    @(negedge clk);
    chk(state, 2'b00, "R1 reset state");
    do_reset();

    // table walk against reference model (R4, with R6 latency)
    for (int i = 0; i < NSTIM; i++) begin
      step(STIM[i]);
      chk(state, m_state, "R4 table walk");
    end

    // directed: input held high from reset release
    do_reset();
    step(1'b1); chk(state, 2'b01, "R6 input not seen yet, edge1");
    step(1'b1); chk(state, 2'b10, "R6 input not seen yet, edge2");
    checks++;
    if (state[1] !== 1'b1 || state[0] !== 1'b0) begin
      errors++;
      $display("FAIL R7: bits act=%b%b exp=10", state[1], state[0]);
    end
    step(1'b1); chk(state, 2'b01, "R2 R3 from 10 with in=1");
    step(1'b1); chk(state, 2'b11, "R5 from 01 with in=1");
    step(1'b1); chk(state, 2'b00, "R4 from 11 with in=1");
    step(1'b1); chk(state, 2'b00, "R3 hold at 00 with in=1");

    // bit 1 set path: from 01 with in=0 -> 10
    do_reset();
    step(1'b0); chk(state, 2'b01, "R2 toggle bit0 from 00 in=0");
    step(1'b0); chk(state, 2'b10, "R3 set bit1 from 01 in=0");

    // asynchronous mid-cycle reset, input high during reset
    step(1'b1);
    step(1'b1);
    #1 rst_n = 1'b0;
    #1 chk(state, 2'b00, "R1 async clear before edge");
    m_state = 2'b00;
    m_pipe = '0;
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b1); chk(state, 2'b01, "R1 synchronizer cleared by reset");
    step(1'b1); chk(state, 2'b10, "R6 two-stage latency after reset");
    step(1'b1); chk(state, m_state, "R4 model after reset");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule